// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped controller that issues clause 22 management frames on a two-wire MDC/MDIO pair toward PHY devices. A host programs a combined PHY/register address word. It then either writes a 16-bit value into the write-data register, which sends a write frame at once, or produces a rising edge on the read-command bit, which sends a read frame. While the frame runs, the host polls an indication word. When a read has finished, it collects the returned value from the read-data register.

A configuration word selects the MDC divider. Writing it with the top bit set aborts any frame in flight and returns the pins to idle. The MDC pin is driven only while a frame is in progress. MDIO changes on MDC falling edges and is sampled on MDC rising edges. During the turnaround and data bits of a read, the output enable is released so that the PHY can drive the line.

Top module: `mdio_master`

## Requirements
- R1: Registers decode `reg_addr` as 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 indication. Reading the address register returns the PHY number in bits 12:8 and the register number in bits 4:0, with all other bits zero. Reading the configuration register returns the divider field in bits 2:0.
- R2: A write to offset 3 while idle sends a 64-bit frame, MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY number, the 5-bit register number, turnaround 10, and the 16 data bits. The output enable stays high for all 64 bits.
- R3: A read frame starts only when a write to offset 1 changes bit 0 from 0 to 1. Writing 1 while the bit is already 1 starts nothing.
- R4: A read frame carries opcode 10. The output enable is high for bits 0–45 and low for bits 46–63. The 16 bits sampled on the last 16 MDC rising edges, first bit as MSB, appear in bits 15:0 of offset 4.
- R5: Indication bit 0 (busy) is set for the whole frame. Indication bit 2 (not-valid) is set from the launch of a read until its data is captured, and is never set by a write frame.
- R6: With divider field N, MDC has period 2·(N+1) system clocks. MDC is low whenever no frame is running, and MDIO never changes while MDC is high.
- R7: A write to offset 3 or a 0→1 command edge that arrives while busy is ignored. The frame in progress is unchanged, no new frame follows, and offset 3 keeps its previous value.
- R8: A write to offset 0 with bit 31 set aborts the frame and clears busy and not-valid. On the next cycle it forces MDC low and the output enable low. The divider field is loaded from bits 2:0 of the same write.
- R9: After reset the divider field is 7, the indication word is 0, MDC is low and the output enable is low.
- R10: Busy stays set for exactly 128·(N+1) system clocks after the launching write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The hardest states to reach are a second command landing in the middle of a running frame, and a soft reset cutting a read frame short. The host must hit these while MDC is toggling, not between frames. The stimulus does this by starting a frame, waiting a fixed number of cycles, and then issuing the competing write, read edge or abort. It then checks the captured MDIO bit stream, the enable pattern and the register readback. Randomized frames with random PHY and register numbers, data and divider values are mixed with directed all-ones and all-zeros reads.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    typedef enum logic [2:0] {
        SEL_CFG = 3'd0,
        SEL_CMD = 3'd1,
        SEL_ADR = 3'd2,
        SEL_DAT = 3'd3,
        SEL_STS = 3'd4,
        SEL_IND = 3'd5
    } reg_sel_e;

    typedef logic [5:0] bit_idx_t;
    localparam bit_idx_t TA_IDX   = 6'd46;
    localparam bit_idx_t DATA_IDX = 6'd48;
    localparam bit_idx_t LAST_IDX = 6'd63;

    typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mgmt_req_t;

    function automatic logic [63:0] build_frame(input mgmt_req_t r);
        logic [1:0] op;
        logic [1:0] ta;
        op = r.rd ? 2'b10 : 2'b01;
        ta = r.rd ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, 2'b01, op, r.phy, r.regad, ta,
                r.rd ? 16'hFFFF : r.data};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             tick_rise,
    output logic             tick_fall
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap      = en && (cnt >= div);
    assign tick_rise = wrap && !mdc;
    assign tick_fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || halt || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: clock parks low once the engine is idle
    p_mdc_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        abort,
    input  logic        start,
    input  mgmt_req_t   req,
    input  logic        tick_rise,
    input  logic        tick_fall,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    eng_state_e  st;
    logic [63:0] sh;
    bit_idx_t    idx;
    logic        is_rd;
    logic [15:0] cap;

    assign active  = (st == ENG_RUN);
    assign done    = active && tick_fall && (idx == LAST_IDX);
    assign mdio_o  = active ? sh[63] : 1'b1;
    assign mdio_oe = active && !(is_rd && idx >= TA_IDX);
    assign rd_data = cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (active && tick_rise && is_rd && idx >= DATA_IDX) begin
            cap <= {cap[14:0], mdio_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st    <= ENG_IDLE;
            idx   <= '0;
            is_rd <= 1'b0;
            sh    <= '1;
        end else if (st == ENG_IDLE) begin
            if (start) begin
                st    <= ENG_RUN;
                sh    <= build_frame(req);
                idx   <= '0;
                is_rd <= req.rd;
            end
        end else if (tick_fall) begin
            if (idx == LAST_IDX) begin
                st <= ENG_IDLE;
            end else begin
                idx <= idx + 1'b1;
                sh  <= {sh[62:0], 1'b1};
            end
        end
    end

    // R10: a frame only ends on an MDC falling edge or an abort
    p_busy_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(abort) || $past(tick_fall)));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 3,
    parameter int DIV_RESET = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

    logic [DIV_W-1:0] div_q;
    logic             cmd_q;
    logic [4:0]       phy_q, regad_q;
    logic [15:0]      ctrl_q, stat_q;
    logic             nv_q;

    logic busy, done, tick_rise, tick_fall;
    logic [15:0] rd_data;
    mgmt_req_t req;

    logic wr_cfg, wr_cmd, wr_adr, wr_dat, soft_rst, wr_launch, rd_launch;
    logic unused_wdata;

    assign wr_cfg    = reg_wr && reg_addr == SEL_CFG;
    assign wr_cmd    = reg_wr && reg_addr == SEL_CMD;
    assign wr_adr    = reg_wr && reg_addr == SEL_ADR;
    assign wr_dat    = reg_wr && reg_addr == SEL_DAT;
    assign soft_rst  = wr_cfg && reg_wdata[31];
    assign wr_launch = wr_dat && !busy;
    assign rd_launch = wr_cmd && reg_wdata[0] && !cmd_q && !busy;
    assign unused_wdata = ^{reg_wdata[30:16]};

    always_comb begin
        req.rd    = rd_launch;
        req.phy   = phy_q;
        req.regad = regad_q;
        req.data  = reg_wdata[15:0];
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .halt(soft_rst), .en(busy), .div(div_q),
        .mdc(mdc), .tick_rise(tick_rise), .tick_fall(tick_fall)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst(rst), .abort(soft_rst), .start(wr_launch || rd_launch),
        .req(req), .tick_rise(tick_rise), .tick_fall(tick_fall), .mdio_i(mdio_i),
        .active(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= DIV_INIT;
            cmd_q   <= 1'b0;
            phy_q   <= '0;
            regad_q <= '0;
            ctrl_q  <= '0;
            stat_q  <= '0;
            nv_q    <= 1'b0;
        end else begin
            if (wr_cfg)    div_q <= reg_wdata[DIV_W-1:0];
            if (wr_cmd)    cmd_q <= reg_wdata[0];
            if (wr_adr) begin
                phy_q   <= reg_wdata[12:8];
                regad_q <= reg_wdata[4:0];
            end
            if (wr_launch) ctrl_q <= reg_wdata[15:0];
            if (soft_rst)       nv_q <= 1'b0;
            else if (rd_launch) nv_q <= 1'b1;
            else if (done)      nv_q <= 1'b0;
            if (done && nv_q && !soft_rst) stat_q <= rd_data;
        end
    end

    always_comb begin
        case (reg_addr)
            SEL_CFG: reg_rdata = {{(32-DIV_W){1'b0}}, div_q};
            SEL_CMD: reg_rdata = {31'b0, cmd_q};
            SEL_ADR: reg_rdata = {19'b0, phy_q, 3'b0, regad_q};
            SEL_DAT: reg_rdata = {16'b0, ctrl_q};
            SEL_STS: reg_rdata = {16'b0, stat_q};
            SEL_IND: reg_rdata = {29'b0, nv_q, 1'b0, busy};
            default: reg_rdata = '0;
        endcase
    end

    // R5: not-valid only while a frame is running
    p_nv_within_busy_r5: assert property (@(posedge clk) disable iff (rst)
        nv_q |-> busy);
    // R6: data line holds while the clock is high
    p_mdio_stable_high_r6: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc) && busy && $past(busy)) |-> $stable(mdio_o));
    // R7: data register ignores writes during a frame
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_dat) |=> $stable(ctrl_q));
    // R8: abort returns the pins and flags to idle
    p_abort_clears_r8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!busy && !nv_q && !mdio_oe && !mdc));
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0;
    int n_bad = 0;
    int rcount = 0;
    logic [15:0] resp = '0;
    logic cap_o  [64];
    logic cap_oe [64];
    longint t0 = 0, t1 = 0;

    always #5 clk = ~clk;

    mdio_master uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY responder: presents data bits ahead of the rising edges that sample them
    assign mdio_i = (rcount >= 48 && rcount < 64) ? resp[63-rcount] : 1'b1;

    always @(posedge mdc) begin
        if (rcount < 64) begin
            cap_o[rcount]  = mdio_o;
            cap_oe[rcount] = mdio_oe;
            if (rcount == 0) t0 = longint'($time);
            if (rcount == 1) t1 = longint'($time);
        end
        rcount = rcount + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] d);
        return {{32{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
    endfunction

    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] val, input int div);
        logic [31:0] v;
        logic [63:0] co, coe, ef;
        int busy_cyc;
        bit nv_first, nv_bad;
        wr(3'd0, 32'(div));
        wr(3'd2, {19'b0, phy, 3'b0, ra});
        resp = val;
        rcount = 0;
        if (rd) begin
            wr(3'd1, 32'd0);
            wr(3'd1, 32'd1);
        end else begin
            wr(3'd3, {16'b0, val});
        end
        busy_cyc = 0; nv_first = 0; nv_bad = 0;
        while (1) begin
            @(negedge clk);
            rdreg(3'd5, v);
            if (busy_cyc == 0) nv_first = v[2];
            if (!v[0]) begin
                if (v[2]) nv_bad = 1;
                break;
            end
            if (!rd && v[2]) nv_bad = 1;
            busy_cyc++;
            if (busy_cyc > 100000) break;
        end
        chk("R10 busy length", 64'(busy_cyc), 64'(128 * (div + 1)));
        chk("R5 not-valid flag", {62'b0, nv_first, nv_bad}, {62'b0, rd, 1'b0});
        chk("R6 mdc period", 64'(t1 - t0), 64'(20 * (div + 1)));
        chk("R2 bit count", 64'(rcount), 64'd64);
        for (int i = 0; i < 64; i++) begin
            co[63-i]  = cap_o[i];
            coe[63-i] = cap_oe[i];
        end
        ef = exp_frame(rd, phy, ra, val);
        if (rd) begin
            chk("R4 read header", {18'b0, co[63:18]}, {18'b0, ef[63:18]});
            chk("R4 enable pattern", coe, {{46{1'b1}}, {18{1'b0}}});
            rdreg(3'd4, v);
            chk("R4 read data", {32'b0, v}, {48'b0, val});
        end else begin
            chk("R2 write frame", co, ef);
            chk("R2 enable pattern", coe, {64{1'b1}});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R9 reset state
        @(negedge clk);
        rdreg(3'd0, v); chk("R9 divider", {32'b0, v}, 64'd7);
        rdreg(3'd5, v); chk("R9 indication", {32'b0, v}, 64'd0);
        chk("R9 pins", {62'b0, mdc, mdio_oe}, 64'd0);

        // R1 register readback
        wr(3'd2, 32'h0000_1F05);
        @(negedge clk); rdreg(3'd2, v); chk("R1 address", {32'b0, v}, 64'h1F05);
        wr(3'd2, 32'hFFFF_FFFF);
        @(negedge clk); rdreg(3'd2, v); chk("R1 address mask", {32'b0, v}, 64'h1F1F);
        wr(3'd0, 32'd2);
        @(negedge clk); rdreg(3'd0, v); chk("R1 divider", {32'b0, v}, 64'd2);

        // directed frames
        run_frame(1'b0, 5'h1F, 5'h00, 16'h8001, 0);
        run_frame(1'b1, 5'h01, 5'h1F, 16'h0000, 1);
        run_frame(1'b1, 5'h15, 5'h0A, 16'hFFFF, 0);

        // R3: writing 1 when the command bit is already 1 starts nothing
        rcount = 0;
        wr(3'd1, 32'd1);
        repeat (40) @(negedge clk);
        rdreg(3'd5, v);
        chk("R3 no relaunch busy", {32'b0, v}, 64'd0);
        chk("R3 no relaunch clocks", 64'(rcount), 64'd0);

        // randomized frames
        for (int k = 0; k < 8; k++) begin
            run_frame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                      int'($urandom % 3));
        end

        // R7: commands during a running frame are ignored
        wr(3'd0, 32'd1);
        wr(3'd2, 32'h0000_0203);
        rcount = 0;
        wr(3'd3, 32'h0000_A5C3);
        repeat (50) @(negedge clk);
        wr(3'd3, 32'h0000_1234);
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        @(negedge clk);
        rdreg(3'd5, v); chk("R7 no not-valid", {63'b0, v[2]}, 64'd0);
        rdreg(3'd3, v); chk("R7 data register kept", {32'b0, v}, 64'hA5C3);
        repeat (900) @(negedge clk);
        rdreg(3'd5, v); chk("R7 idle after frame", {32'b0, v}, 64'd0);
        chk("R7 single frame", 64'(rcount), 64'd64);
        begin
            logic [63:0] co;
            for (int i = 0; i < 64; i++) co[63-i] = cap_o[i];
            chk("R7 frame unchanged", co, exp_frame(1'b0, 5'h02, 5'h03, 16'hA5C3));
        end

        // R8: soft reset in the middle of a read
        rcount = 0;
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        repeat (100) @(negedge clk);
        rdreg(3'd5, v); chk("R8 running before abort", {32'b0, v}, 64'd5);
        wr(3'd0, 32'h8000_0002);
        @(negedge clk);
        rdreg(3'd5, v); chk("R8 flags cleared", {32'b0, v}, 64'd0);
        chk("R8 pins idle", {62'b0, mdc, mdio_oe}, 64'd0);
        rdreg(3'd0, v); chk("R8 divider loaded", {32'b0, v}, 64'd2);
        begin
            int rc;
            rc = rcount;
            repeat (100) @(negedge clk);
            chk("R8 clock stopped", 64'(rcount), 64'(rc));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule